// File: doc/BRIEF.md
# Periodic Calibration Blocking Scheduler

This block sequences the periodic impedance-calibration cycle of a memory controller. It counts one-cycle maintenance ticks. Once a programmed number of ticks has arrived, it opens a blocking window of a programmed number of memory clock cycles. For the whole window it holds a block-all-commands output high, so that the command scheduler issues nothing while the calibration circuit updates.

Inside the window it gives two one-cycle update strobes. The command-calibration strobe fires at a programmed cycle offset from the window start. The data-calibration strobe fires on the last cycle of the window.

The interval field uses minus-one encoding: a value of N means N+1 ticks. Ticks are counted from reset, from the moment the scheduler is enabled, or from the end of the previous window. The length and offset fields are captured when a window opens. The recommended operating values are offset 15 and length 31. The reset-time values (enable 1, offset 2, length 9, interval 0) are supplied by whatever drives the configuration inputs.

Top module: `cal_window_sched`

## Requirements
- R1: After reset, with no tick yet sampled, `block_all`, `cmd_cal_stb` and `data_cal_stb` are all low.
- R2: While `cfg_enable` is 0, no window opens and neither strobe fires, whatever ticks arrive. In the cycle after any cycle with `cfg_enable` low, `block_all` is low.
- R3: With `cfg_interval` = N, the window opens on the (N+1)th tick accepted since reset, enable, or the end of the last window. `block_all` first goes high in the cycle that follows the clock edge that samples that tick.
- R4: `block_all` stays high for exactly `cfg_length` consecutive cycles. A length of 0 gives a one-cycle window.
- R5: `cmd_cal_stb` is high for exactly one cycle, at window cycle index `cfg_cmd_offset`, where index 0 is the first cycle with `block_all` high. It does not fire in that window if the offset is greater than or equal to the effective length.
- R6: `data_cal_stb` is high for exactly one cycle: the last cycle of the window. `block_all` is low in the cycle after it.
- R7: The length and offset are captured on the edge that opens the window. Changing them while the window is open does not affect that window.
- R8: Ticks that arrive while a window is open are not counted toward the next interval.
- R9: If `cfg_enable` goes low during a window, `block_all` drops in that same cycle and no strobe fires for the rest of that window. A later window needs a full interval of ticks after enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| maint_tick | input | 1 | One-cycle maintenance tick |
| cfg_enable | input | 1 | Calibration scheduling enable |
| cfg_interval | input | INT_W (4) | Ticks between calibrations, minus one |
| cfg_length | input | LEN_W (6) | Blocking window length in cycles (0 means 1) |
| cfg_cmd_offset | input | LEN_W (6) | Window cycle index of the command strobe |
| block_all | output | 1 | Block all commands while high |
| cmd_cal_stb | output | 1 | Command-calibration update strobe |
| data_cal_stb | output | 1 | Data-calibration update strobe |

## Verification
The bench builds the block with its default widths: a 4-bit interval and 6-bit length and offset fields. At these widths the recommended 31-cycle window and a four-tick interval are cheap to run in full. The widths also cover the degenerate lengths 0 and 1 and an offset equal to the length. A window that is abandoned part-way when enable drops is exercised as well, and every case stays within a few hundred cycles.

// File: rtl/cal_sched_pkg.sv
package cal_sched_pkg;
  parameter int CAL_INT_W = 4;
  parameter int CAL_LEN_W = 6;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_e;
endpackage

// File: rtl/cal_tick_counter.sv
module cal_tick_counter #(
  parameter int INT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             busy,
  input  logic             win_done,
  input  logic [INT_W-1:0] interval,
  output logic             fire
);
  logic [INT_W-1:0] tick_cnt;
  logic             tick_ok;

  // Minus-one encoding: counter equal to the field means N+1 ticks seen.
  function automatic logic interval_reached(input logic [INT_W-1:0] cnt,
                                            input logic [INT_W-1:0] lim);
    return cnt >= lim;
  endfunction

  assign tick_ok = en & tick & ~busy;
  assign fire    = tick_ok & interval_reached(tick_cnt, interval);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
    end else if (!en || win_done || fire) begin
      tick_cnt <= '0;
    end else if (tick_ok) begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cal_window_timer.sv
module cal_window_timer
  import cal_sched_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic [LEN_W-1:0] len_raw,
  input  logic [LEN_W-1:0] off_raw,
  output logic             active,
  output logic             last,
  output logic [LEN_W-1:0] idx,
  output logic [LEN_W-1:0] len_q,
  output logic [LEN_W-1:0] off_q
);
  win_state_e state;

  function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] l);
    return (l == '0) ? {{(LEN_W-1){1'b0}}, 1'b1} : l;
  endfunction

  assign active = (state == WIN_OPEN);
  assign last   = active && (idx == len_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= WIN_IDLE;
      idx   <= '0;
      len_q <= {{(LEN_W-1){1'b0}}, 1'b1};
      off_q <= '0;
    end else begin
      case (state)
        WIN_IDLE: begin
          if (start) begin
            state <= WIN_OPEN;
            idx   <= '0;
            len_q <= eff_len(len_raw);
            off_q <= off_raw;
          end
        end
        WIN_OPEN: begin
          if (!en || last) begin
            state <= WIN_IDLE;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= WIN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cal_strobe_gen.sv
module cal_strobe_gen #(
  parameter int LEN_W = 6
) (
  input  logic             en,
  input  logic             active,
  input  logic             last,
  input  logic [LEN_W-1:0] idx,
  input  logic [LEN_W-1:0] len_q,
  input  logic [LEN_W-1:0] off_q,
  output logic             block,
  output logic             cmd_stb,
  output logic             data_stb
);
  function automatic logic cmd_due(input logic [LEN_W-1:0] i,
                                   input logic [LEN_W-1:0] off,
                                   input logic [LEN_W-1:0] len);
    return (i == off) && (off < len);
  endfunction

  assign block    = active & en;
  assign cmd_stb  = block & cmd_due(idx, off_q, len_q);
  assign data_stb = block & last;
endmodule

// File: rtl/cal_window_sched.sv
module cal_window_sched
  import cal_sched_pkg::*;
#(
  parameter int INT_W = CAL_INT_W,
  parameter int LEN_W = CAL_LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             maint_tick,
  input  logic             cfg_enable,
  input  logic [INT_W-1:0] cfg_interval,
  input  logic [LEN_W-1:0] cfg_length,
  input  logic [LEN_W-1:0] cfg_cmd_offset,
  output logic             block_all,
  output logic             cmd_cal_stb,
  output logic             data_cal_stb
);
  logic             win_fire;
  logic             win_active;
  logic             win_last;
  logic [LEN_W-1:0] win_idx;
  logic [LEN_W-1:0] win_len;
  logic [LEN_W-1:0] win_off;

  cal_tick_counter #(.INT_W(INT_W)) u_ticks (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg_enable),
    .tick     (maint_tick),
    .busy     (win_active),
    .win_done (win_last),
    .interval (cfg_interval),
    .fire     (win_fire)
  );

  cal_window_timer #(.LEN_W(LEN_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg_enable),
    .start   (win_fire),
    .len_raw (cfg_length),
    .off_raw (cfg_cmd_offset),
    .active  (win_active),
    .last    (win_last),
    .idx     (win_idx),
    .len_q   (win_len),
    .off_q   (win_off)
  );

  cal_strobe_gen #(.LEN_W(LEN_W)) u_stb (
    .en       (cfg_enable),
    .active   (win_active),
    .last     (win_last),
    .idx      (win_idx),
    .len_q    (win_len),
    .off_q    (win_off),
    .block    (block_all),
    .cmd_stb  (cmd_cal_stb),
    .data_stb (data_cal_stb)
  );
endmodule

// File: rtl/cal_sched_chk.sv
module cal_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic maint_tick,
  input logic cfg_enable,
  input logic block_all,
  input logic cmd_cal_stb,
  input logic data_cal_stb,
  input logic win_fire
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !block_all); // R1
  AST_DISABLED_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !block_all); // R2
  AST_OPEN_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(block_all) |-> $past(maint_tick) && $past(win_fire)); // R3
  AST_HOLD_UNTIL_END: assert property (@(posedge clk) disable iff (!rst_n)
    (block_all && !data_cal_stb) |=> (block_all || !cfg_enable)); // R4
  AST_CMD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cal_stb |-> block_all); // R5
  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cal_stb |=> !cmd_cal_stb); // R5
  AST_DATA_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    data_cal_stb |=> !block_all); // R6
  AST_DATA_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    data_cal_stb |-> block_all); // R6
endmodule

bind cal_window_sched cal_sched_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .maint_tick   (maint_tick),
  .cfg_enable   (cfg_enable),
  .block_all    (block_all),
  .cmd_cal_stb  (cmd_cal_stb),
  .data_cal_stb (data_cal_stb),
  .win_fire     (win_fire)
);

// File: tb/cal_window_sched_tb_top.sv
`timescale 1ns/1ps
module cal_window_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       maint_tick = 1'b0;
  logic       cfg_enable = 1'b1;
  logic [3:0] cfg_interval = 4'd0;
  logic [5:0] cfg_length = 6'd9;
  logic [5:0] cfg_cmd_offset = 6'd2;
  logic       block_all, cmd_cal_stb, data_cal_stb;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  int start_cyc, blk_len, cmd_cnt, cmd_idx, data_cnt, data_idx, win_cnt, tick_cyc, stray;
  logic prev_blk = 1'b0;

  always #5 clk = ~clk;

  cal_window_sched dut_i (
    .clk(clk), .rst_n(rst_n), .maint_tick(maint_tick), .cfg_enable(cfg_enable),
    .cfg_interval(cfg_interval), .cfg_length(cfg_length), .cfg_cmd_offset(cfg_cmd_offset),
    .block_all(block_all), .cmd_cal_stb(cmd_cal_stb), .data_cal_stb(data_cal_stb)
  );

  // Monitor: samples 2 ns after each rising edge.
  always @(posedge clk) begin
    cyc = cyc + 1;
    #2;
    if (maint_tick) tick_cyc = cyc;
    if ((cmd_cal_stb || data_cal_stb) && !block_all) stray = stray + 1;
    if (block_all) begin
      if (!prev_blk) begin
        start_cyc = cyc;
        win_cnt = win_cnt + 1;
      end
      blk_len = blk_len + 1;
      if (cmd_cal_stb) begin cmd_cnt = cmd_cnt + 1; cmd_idx = cyc - start_cyc; end
      if (data_cal_stb) begin data_cnt = data_cnt + 1; data_idx = cyc - start_cyc; end
    end
    prev_blk = block_all;
  end

  task automatic clear_mon();
    start_cyc = -1; blk_len = 0; cmd_cnt = 0; cmd_idx = -1;
    data_cnt = 0; data_idx = -1; win_cnt = 0; stray = 0;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic send_tick();
    @(negedge clk) maint_tick = 1'b1;
    @(negedge clk) maint_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected window shape, worked out from the requirements.
  task automatic chk_window(input string req, input int len, input int off);
    int el;
    el = (len == 0) ? 1 : len;
    chk_eq({req, " length"}, blk_len, el);
    chk_eq({req, " data strobe count"}, data_cnt, 1);
    chk_eq({req, " data strobe index"}, data_idx, el - 1);
    chk_eq({req, " cmd strobe count"}, cmd_cnt, (off < el) ? 1 : 0);
    if (off < el) chk_eq({req, " cmd strobe index"}, cmd_idx, off);
    chk_eq({req, " strobe outside window"}, stray, 0);
  endtask

  task automatic t_reset();
    #2;
    chk_eq("R1 block at reset", int'(block_all), 0);
    chk_eq("R1 cmd at reset", int'(cmd_cal_stb), 0);
    chk_eq("R1 data at reset", int'(data_cal_stb), 0);
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk_eq("R1 block after reset", int'(block_all), 0);
  endtask

  task automatic t_basic();
    clear_mon();
    cfg_interval = 0; cfg_length = 9; cfg_cmd_offset = 2;
    send_tick();
    idle(20);
    chk_eq("R3 one window", win_cnt, 1);
    chk_eq("R3 open cycle", start_cyc, tick_cyc);
    chk_window("R4 R5 R6 basic", 9, 2);
  endtask

  task automatic t_interval();
    clear_mon();
    cfg_interval = 3; cfg_length = 31; cfg_cmd_offset = 15;
    for (int i = 0; i < 3; i++) begin send_tick(); idle(3); end
    chk_eq("R3 no window after 3 ticks", win_cnt, 0);
    send_tick();
    idle(40);
    chk_eq("R3 window after 4th tick", win_cnt, 1);
    chk_eq("R3 open on 4th tick", start_cyc, tick_cyc);
    chk_window("R4 R5 R6 recommended", 31, 15);
  endtask

  task automatic t_off_ge_len();
    clear_mon();
    cfg_interval = 0; cfg_length = 5; cfg_cmd_offset = 5;
    send_tick();
    idle(12);
    chk_window("R5 offset equals length", 5, 5);
    clear_mon();
    cfg_cmd_offset = 40;
    send_tick();
    idle(12);
    chk_window("R5 offset beyond length", 5, 40);
  endtask

  task automatic t_len0();
    clear_mon();
    cfg_interval = 0; cfg_length = 0; cfg_cmd_offset = 0;
    send_tick();
    idle(6);
    chk_window("R4 zero length", 0, 0);
    clear_mon();
    cfg_length = 1;
    send_tick();
    idle(6);
    chk_window("R6 one-cycle length", 1, 0);
  endtask

  task automatic t_latch();
    clear_mon();
    cfg_interval = 0; cfg_length = 10; cfg_cmd_offset = 3;
    send_tick();
    cfg_length = 2; cfg_cmd_offset = 7;
    idle(20);
    chk_window("R7 captured fields", 10, 3);
  endtask

  task automatic t_ignore();
    clear_mon();
    cfg_interval = 1; cfg_length = 20; cfg_cmd_offset = 0;
    send_tick(); idle(2); send_tick();
    idle(3);
    send_tick();          // lands inside the window
    idle(30);
    chk_eq("R8 first window", win_cnt, 1);
    send_tick();
    idle(5);
    chk_eq("R8 tick during window not counted", win_cnt, 1);
    send_tick();
    idle(2);
    chk_eq("R8 second window opens", win_cnt, 2);
    chk_eq("R3 second window open cycle", start_cyc, tick_cyc);
    idle(30);
  endtask

  task automatic t_disable();
    clear_mon();
    cfg_interval = 0; cfg_length = 9; cfg_cmd_offset = 2;
    cfg_enable = 1'b0;
    for (int i = 0; i < 5; i++) begin send_tick(); idle(2); end
    idle(15);
    chk_eq("R2 no window while disabled", win_cnt, 0);
    chk_eq("R2 no cmd strobe", cmd_cnt, 0);
    chk_eq("R2 no data strobe", data_cnt, 0);
    cfg_enable = 1'b1;
    idle(2);
  endtask

  task automatic t_abort();
    clear_mon();
    cfg_interval = 0; cfg_length = 30; cfg_cmd_offset = 20;
    send_tick();
    idle(5);
    cfg_enable = 1'b0;
    #1;
    chk_eq("R9 block drops same cycle", int'(block_all), 0);
    idle(40);
    chk_eq("R9 abandoned window length", blk_len, 6);
    chk_eq("R9 no cmd strobe", cmd_cnt, 0);
    chk_eq("R9 no data strobe", data_cnt, 0);
    cfg_enable = 1'b1;
    cfg_interval = 1;
    clear_mon();
    send_tick();
    idle(3);
    chk_eq("R9 one tick not enough after re-enable", win_cnt, 0);
    send_tick();
    idle(40);
    chk_eq("R9 full window after re-enable", win_cnt, 1);
    chk_window("R9 window after re-enable", 30, 20);
  endtask

  initial begin
    clear_mon();
    tick_cyc = -1;
    t_reset();
    t_basic();
    t_interval();
    t_off_ge_len();
    t_len0();
    t_latch();
    t_ignore();
    t_disable();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule